// File: doc/BRIEF.md
# Dual-role serial peripheral port

This block is one full-duplex serial port for an 8-bit serial peripheral bus. It works either as the bus master or as a bus slave. One shift engine serves both roles. A control register selects the role, the clock polarity and the clock phase. As master, the port makes its serial clock from the system clock through a fixed divider and runs one frame each time software writes the transmit register. As slave, it brings an external serial clock into the system clock domain through a synchronizer and shifts on the edges it finds there.

Software reaches the port through four host-side registers, selected by a 2-bit address:

- Address 0: control.
- Address 1: data. A write is the transmit byte; a read returns the receive byte.
- Address 2: status.
- Address 3: unused, reads as zero.

A one-cycle pulse marks the end of each frame. Frames are always eight bits long and travel most significant bit first. The role and clock settings are locked while the port is enabled.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset, the control register reads 0 (slave, polarity 0, phase 0, disabled), status reads 0, `sclk_o` is low and `xfer_done` is low.
- R2: The control register has these bits: bit 0 is enable, bit 1 is role (1 = master), bit 2 is polarity and bit 3 is phase. Bit 0 can always be written. A write to bits 1 to 3 takes effect only if enable was 0 before the write; otherwise those bits keep their values.
- R3: In master mode, with the port enabled and not busy, a write to address 1 starts a frame. `sdo` sends that byte MSB first. The 8 bits sampled from `sdi`, first bit as MSB, can afterwards be read at address 1. This holds for all four polarity/phase combinations.
- R4: In master mode, `sclk_o` rests at the polarity level. Each frame makes exactly 8 leading edges and returns to the rest level. With phase 0, data is sampled on the leading edge and `sdo` changes on the trailing edge. With phase 1, `sdo` changes on the leading edge and data is sampled on the trailing edge.
- R5: Each frame raises `xfer_done` for exactly one cycle and sets status bit 1 (receive full). Reading address 1 clears status bit 1. Status bit 0 is busy and reads 1 while a frame runs.
- R6: A write to address 1 while the port is busy is ignored. The frame in progress still sends the byte written first.
- R7: While enable is 0, a write to address 1 starts nothing: `sclk_o` makes no edge, busy stays 0 and `xfer_done` stays low.
- R8: In slave mode, the port shifts on the edges of `sclk_i` under the same polarity/phase rules as R4. After 8 sampled bits, the received byte is readable at address 1 and `xfer_done` pulses. Meanwhile, `sdo` has sent the byte last written to address 1, MSB first.
- R9: In slave mode, while enabled and idle, `sdo` holds the MSB of the byte last written to address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (a read of address 1 clears receive full) |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data of the selected register |
| xfer_done | output | 1 | One-cycle pulse at the end of each frame |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | External serial clock used in slave mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
- A bit counter that slips or a shift register loaded in the wrong phase shows within the same frame. The byte captured from `sdo`, or the byte read back from address 1, comes out rotated or shifted by one place. The done pulse either arrives an edge early or late, or goes missing.
- A wrong divider or toggle count shows as a leading-edge count other than 8. It also shows as a serial clock that does not return to its rest level before busy drops.
- A wrong lock on the control register shows at the next read of address 0.
- A wrong idle reload in slave mode shows on `sdo` before the first external edge.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
   localparam int FRAME_BITS = 8;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_DATA = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   typedef struct packed {
      logic cpha;
      logic cpol;
      logic master;
      logic en;
   } spi_cfg_t;
endpackage

// File: rtl/spi_cfg_reg.sv
module spi_cfg_reg
   import spi_duplex_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [3:0] wdata,
   output spi_cfg_t   cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr) begin
         cfg.en <= wdata[0];
         if (!cfg.en) begin
            cfg.master <= wdata[1];
            cfg.cpol   <= wdata[2];
            cfg.cpha   <= wdata[3];
         end
      end
   end

   // R2: role and clock bits frozen by a write made while enabled
   p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && cfg.en) |=> ($stable(cfg.master) && $stable(cfg.cpol) && $stable(cfg.cpha)));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
   import spi_duplex_pkg::*;
#(
   parameter int HALF_DIV = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic halt,
   output logic phase,
   output logic lead,
   output logic trail,
   output logic running
);
   localparam int TOGGLES = 2 * FRAME_BITS;
   localparam int TW      = $clog2(TOGGLES);

   logic [TW-1:0] tcnt;
   logic          tick;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = running;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         logic [DW-1:0] dcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                dcnt <= '0;
            else if (!running || tick) dcnt <= '0;
            else                       dcnt <= dcnt + 1'b1;
         end
         assign tick = running && (dcnt == DW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         phase   <= 1'b0;
         tcnt    <= '0;
      end else if (halt) begin
         running <= 1'b0;
         phase   <= 1'b0;
         tcnt    <= '0;
      end else if (!running) begin
         running <= start;
         phase   <= 1'b0;
         tcnt    <= '0;
      end else if (tick) begin
         phase <= ~phase;
         tcnt  <= tcnt + 1'b1;
         if (tcnt == TW'(TOGGLES - 1)) running <= 1'b0;
      end
   end

   assign lead  = tick && !phase;
   assign trail = tick && phase;

   // R4: clock rests in its idle phase whenever no frame runs
   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !phase);
   // R4: a frame ends only on a trailing toggle
   p_end_on_trail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !halt) |=> (running || $past(trail)));
endmodule

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
   parameter int SYNC_STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdi_i,
   input  logic cpol,
   output logic lead,
   output logic trail,
   output logic sdi_s
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] ck_q;
   logic [SYNC_STAGES-1:0] dt_q;
   logic                   ck_prev;
   logic                   rise;
   logic                   fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_q    <= '0;
         dt_q    <= '0;
         ck_prev <= 1'b0;
      end else begin
         ck_q    <= {ck_q[SYNC_STAGES-2:0], sclk_i};
         dt_q    <= {dt_q[SYNC_STAGES-2:0], sdi_i};
         ck_prev <= ck_q[SYNC_STAGES-1];
      end
   end

   assign rise  = ck_q[SYNC_STAGES-1] && !ck_prev;
   assign fall  = !ck_q[SYNC_STAGES-1] && ck_prev;
   assign lead  = cpol ? fall : rise;
   assign trail = cpol ? rise : fall;
   assign sdi_s = dt_q[SYNC_STAGES-1];

   // R8: a synchronized edge is never reported in two adjacent cycles
   p_edge_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lead || trail) |=> !(lead || trail));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_duplex_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic                  master,
   input  logic                  cpha,
   input  logic                  lead,
   input  logic                  trail,
   input  logic                  sdi,
   input  logic                  tx_load,
   input  logic [FRAME_BITS-1:0] tx_data,
   input  logic                  start_master,
   input  logic                  rx_clr,
   output logic                  sdo,
   output logic                  active,
   output logic [FRAME_BITS-1:0] rx_data,
   output logic                  rx_full,
   output logic                  done
);
   localparam int CW = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] tx_buf;
   logic [FRAME_BITS-1:0] tx_sh;
   logic [FRAME_BITS-1:0] rx_sh;
   logic [CW-1:0]         cnt;
   logic                  start_slave;
   logic                  live;
   logic                  samp;
   logic                  shft;
   logic                  load_ok;

   assign start_slave = en && !master && !active && lead;
   assign live        = active || start_slave;
   assign samp        = live && (cpha ? trail : lead);
   assign shft        = live && (cpha ? lead : trail);
   assign load_ok     = tx_load && !start_slave;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf  <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         rx_data <= '0;
         cnt     <= '0;
         active  <= 1'b0;
         rx_full <= 1'b0;
         done    <= 1'b0;
         sdo     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (rx_clr) rx_full <= 1'b0;
         if (!en) begin
            active <= 1'b0;
            cnt    <= '0;
            sdo    <= tx_buf[FRAME_BITS-1];
            tx_sh  <= cpha ? tx_buf : (tx_buf << 1);
         end else begin
            if (start_master || start_slave) begin
               active <= 1'b1;
               cnt    <= '0;
            end
            if (load_ok) begin
               tx_buf <= tx_data;
               sdo    <= tx_data[FRAME_BITS-1];
               tx_sh  <= cpha ? tx_data : (tx_data << 1);
            end else if (!live) begin
               sdo   <= tx_buf[FRAME_BITS-1];
               tx_sh <= cpha ? tx_buf : (tx_buf << 1);
            end else if (shft) begin
               sdo   <= tx_sh[FRAME_BITS-1];
               tx_sh <= tx_sh << 1;
            end
            if (samp) begin
               rx_sh <= {rx_sh[FRAME_BITS-2:0], sdi};
               cnt   <= cnt + 1'b1;
               if (cnt == CW'(FRAME_BITS - 1)) begin
                  active  <= 1'b0;
                  cnt     <= '0;
                  rx_data <= {rx_sh[FRAME_BITS-2:0], sdi};
                  rx_full <= 1'b1;
                  done    <= 1'b1;
               end
            end
         end
      end
   end

   // R5: the done strobe lasts a single cycle
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5: receive full is raised together with done
   p_done_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rx_full);
   // R3: the bit counter is at zero whenever no frame runs
   p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (cnt == '0));
   // R7: a disabled port never reports a finished frame
   p_no_done_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !done);
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
   import spi_duplex_pkg::*;
#(
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       xfer_done,
   output logic       sclk_o,
   input  logic       sclk_i,
   input  logic       sdi,
   output logic       sdo
);
   spi_cfg_t              cfg;
   logic                  wr_ctrl;
   logic                  wr_tx;
   logic                  rx_clr;
   logic                  busy;
   logic                  m_phase, m_lead, m_trail, m_run;
   logic                  s_lead, s_trail, s_sdi;
   logic                  lead, trail, sdi_sel;
   logic                  eng_active;
   logic                  rx_full;
   logic [FRAME_BITS-1:0] rx_data;
   logic                  mst_on;

   assign mst_on  = cfg.en && cfg.master;
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
   assign busy    = eng_active || m_run;
   assign wr_tx   = reg_wr && (reg_addr == ADDR_DATA) && cfg.en && !busy;
   assign rx_clr  = reg_rd && (reg_addr == ADDR_DATA);

   spi_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ctrl),
      .wdata (reg_wdata[3:0]),
      .cfg   (cfg)
   );

   spi_sclk_gen #(.HALF_DIV(HALF_DIV)) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (wr_tx && cfg.master),
      .halt    (!mst_on),
      .phase   (m_phase),
      .lead    (m_lead),
      .trail   (m_trail),
      .running (m_run)
   );

   spi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (sclk_i),
      .sdi_i  (sdi),
      .cpol   (cfg.cpol),
      .lead   (s_lead),
      .trail  (s_trail),
      .sdi_s  (s_sdi)
   );

   assign lead    = cfg.master ? m_lead  : s_lead;
   assign trail   = cfg.master ? m_trail : s_trail;
   assign sdi_sel = cfg.master ? sdi     : s_sdi;

   spi_shift_engine u_eng (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (cfg.en),
      .master       (cfg.master),
      .cpha         (cfg.cpha),
      .lead         (lead),
      .trail        (trail),
      .sdi          (sdi_sel),
      .tx_load      (wr_tx),
      .tx_data      (reg_wdata),
      .start_master (wr_tx && cfg.master),
      .rx_clr       (rx_clr),
      .sdo          (sdo),
      .active       (eng_active),
      .rx_data      (rx_data),
      .rx_full      (rx_full),
      .done         (xfer_done)
   );

   assign sclk_o = cfg.cpol ^ (mst_on && m_phase);

   always_comb begin
      case (reg_addr)
         ADDR_CTRL: reg_rdata = {4'b0, cfg};
         ADDR_DATA: reg_rdata = rx_data;
         ADDR_STAT: reg_rdata = {6'b0, rx_full, busy};
         default:   reg_rdata = 8'h00;
      endcase
   end

   // R4: the master clock stays at the polarity level while idle
   p_sclk_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk_o == cfg.cpol));
   // R7: no serial clock activity while disabled
   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.en |-> !busy);
endmodule

// File: tb/sim_spi_duplex_port.sv
module sim_spi_duplex_port;
   localparam int CLK_PERIOD = 10;
   localparam int SHALF      = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       xfer_done, sclk_o, sdo;
   logic       sclk_i = 1'b0, sdi = 1'b0;

   int n_chk = 0, n_fail = 0;
   int done_cnt = 0, lead_cnt = 0;
   logic cur_cpol = 1'b0;

   spi_duplex_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .xfer_done(xfer_done), .sclk_o(sclk_o), .sclk_i(sclk_i),
      .sdi(sdi), .sdo(sdo)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (rst_n && xfer_done) done_cnt++;
   always @(sclk_o) if (rst_n && (sclk_o !== cur_cpol)) lead_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   function automatic logic [7:0] ctrl_word(input bit m, input bit p, input bit h, input bit e);
      return {4'b0, h, p, m, e};
   endfunction

   function automatic logic [7:0] stat_word(input bit full, input bit busy);
      return {6'b0, full, busy};
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic setup(input bit m, input bit p, input bit h);
      wr(2'd0, ctrl_word(m, p, h, 1'b0));
      wr(2'd0, ctrl_word(m, p, h, 1'b0));
      cur_cpol = p;
      sclk_i = p;
      repeat (6) @(negedge clk);
      wr(2'd0, ctrl_word(m, p, h, 1'b1));
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      s = 8'h01;
      while (s[0]) rd(2'd2, s);
   endtask

   task automatic master_frame(input bit p, input bit h, input logic [7:0] tx,
                               input logic [7:0] sb, input bit extra_wr);
      logic [7:0] cap, r;
      int lc0, dc0;
      cap = 8'h00;
      lc0 = lead_cnt; dc0 = done_cnt;
      if (!h) sdi = sb[7];
      wr(2'd1, tx);
      if (extra_wr) wr(2'd1, ~tx);
      for (int i = 0; i < 8; i++) begin
         if (!h) begin
            wait (sclk_o != p);
            cap[7-i] = sdo;
            wait (sclk_o == p);
            #1 if (i < 7) sdi = sb[6-i];
         end else begin
            wait (sclk_o != p);
            #1 sdi = sb[7-i];
            wait (sclk_o == p);
            cap[7-i] = sdo;
         end
      end
      wait_idle();
      if (extra_wr) chk("R6 ignored write while busy", cap, tx);
      else          chk("R3 master sdo byte", cap, tx);
      chk("R4 eight leading edges", lead_cnt - lc0, 8);
      chk("R4 clock back at rest", sclk_o, p);
      chk("R5 single done pulse", done_cnt - dc0, 1);
      rd(2'd2, r);
      chk("R5 receive full set", r, stat_word(1'b1, 1'b0));
      rd(2'd1, r);
      chk("R3 master received byte", r, sb);
      rd(2'd2, r);
      chk("R5 receive full cleared by read", r, stat_word(1'b0, 1'b0));
   endtask

   task automatic slave_frame(input bit p, input bit h, input logic [7:0] mb,
                              input logic [7:0] exp_tx);
      logic [7:0] cap, r;
      int dc0;
      cap = 8'h00;
      dc0 = done_cnt;
      for (int i = 0; i < 8; i++) begin
         if (!h) begin
            sdi = mb[7-i];
            repeat (SHALF) @(negedge clk);
            cap[7-i] = sdo;
            sclk_i = ~p;
            repeat (SHALF) @(negedge clk);
            sclk_i = p;
         end else begin
            sclk_i = ~p;
            sdi = mb[7-i];
            repeat (SHALF) @(negedge clk);
            cap[7-i] = sdo;
            sclk_i = p;
            repeat (SHALF) @(negedge clk);
         end
      end
      repeat (8) @(negedge clk);
      chk("R8 slave sdo byte", cap, exp_tx);
      chk("R8 slave done pulse", done_cnt - dc0, 1);
      rd(2'd2, r);
      chk("R8 slave status after frame", r, stat_word(1'b1, 1'b0));
      rd(2'd1, r);
      chk("R8 slave received byte", r, mb);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      summary();
   end

   initial begin
      logic [7:0] r, t, b;
      void'($urandom(32'h5eed_2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(2'd0, r); chk("R1 control after reset", r, 8'h00);
      rd(2'd2, r); chk("R1 status after reset", r, 8'h00);
      chk("R1 sclk_o low", sclk_o, 0);
      chk("R1 done low", xfer_done, 0);

      // R7 disabled: data write starts nothing
      wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 1'b0));
      begin
         int lc0, dc0;
         lc0 = lead_cnt; dc0 = done_cnt;
         wr(2'd1, 8'hA5);
         repeat (40) @(negedge clk);
         chk("R7 no clock edges while off", lead_cnt - lc0, 0);
         chk("R7 no done while off", done_cnt - dc0, 0);
         rd(2'd2, r); chk("R7 not busy while off", r, 8'h00);
      end

      // R2 lock of role/clock bits while enabled
      setup(1'b1, 1'b0, 1'b0);
      wr(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b1));
      rd(2'd0, r); chk("R2 locked bits kept", r, ctrl_word(1'b1, 1'b0, 1'b0, 1'b1));
      wr(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b0));
      rd(2'd0, r); chk("R2 enable clears, mode kept", r, ctrl_word(1'b1, 1'b0, 1'b0, 1'b0));
      wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b0, 1'b0));
      rd(2'd0, r); chk("R2 write accepted when off", r, ctrl_word(1'b1, 1'b1, 1'b0, 1'b0));

      // R3 R4 R5 directed master frames, all four modes
      for (int m = 0; m < 4; m++) begin
         setup(1'b1, m[1], m[0]);
         master_frame(m[1], m[0], 8'hC3 ^ 8'(m), 8'h5A ^ 8'(m << 4), 1'b0);
      end
      setup(1'b1, 1'b0, 1'b0);
      master_frame(1'b0, 1'b0, 8'h80, 8'h01, 1'b0);
      master_frame(1'b0, 1'b0, 8'h01, 8'hFE, 1'b0);

      // R6 write during a busy frame
      setup(1'b1, 1'b1, 1'b1);
      master_frame(1'b1, 1'b1, 8'h3C, 8'h96, 1'b1);

      // R3 constrained random master frames
      for (int k = 0; k < 8; k++) begin
         int md;
         md = int'($urandom_range(3, 0));
         t = 8'($urandom);
         b = 8'($urandom);
         setup(1'b1, md[1], md[0]);
         master_frame(md[1], md[0], t, b, 1'b0);
      end

      // R8 R9 slave frames, all four modes
      for (int m = 0; m < 4; m++) begin
         t = 8'h9D ^ 8'(m * 17);
         setup(1'b0, m[1], m[0]);
         wr(2'd1, t);
         repeat (3) @(negedge clk);
         chk("R9 idle sdo holds first bit", sdo, t[7]);
         slave_frame(m[1], m[0], 8'h6B ^ 8'(m), t);
         repeat (3) @(negedge clk);
         chk("R9 idle sdo after frame", sdo, t[7]);
      end

      // R8 random slave frames, repeated byte without rewrite
      for (int k = 0; k < 4; k++) begin
         int md;
         md = int'($urandom_range(3, 0));
         t = 8'($urandom);
         b = 8'($urandom);
         setup(1'b0, md[1], md[0]);
         wr(2'd1, t);
         slave_frame(md[1], md[0], b, t);
         slave_frame(md[1], md[0], ~b, t);
      end

      summary();
   end
endmodule